// File: doc/BRIEF.md
# SRAM Bank Low-Power Mode Sequencer

This block owns the power and access controls of a bank of single-port SRAM macros and moves the whole bank between four operating levels. In the active level every macro is selected, fully powered and unclamped. In standby only the chip enables drop. In retention the storage arrays keep their supply so that contents survive, but the periphery supply is removed and the data outputs are clamped to zero. In shutdown both supplies are removed, the outputs stay clamped and the contents are lost.

A requester presents a two-bit target level on `modeSel` and holds `modeReq` high. The sequencer then walks the bank one level at a time toward the target and pulses `modeAck` only when the target is reached. When it goes down, it lowers the chip enable, then raises the clamp, then cuts the periphery supply, and last cuts the array supply. When it goes up, it restores a supply, waits a settle period taken from `settleCount`, releases the clamp, and only then re-selects the macros. Before the bank leaves the active level, every access still in flight must finish. An access request that arrives outside the stable active level is stalled. A request that arrives while the bank is shut down also raises a flag, because the contents it would read are gone.

Top module: `mem_lp_ctrl`

## Requirements
- R1: After reset the bank is active: `curMode` = 00, every chip enable, periphery enable and array enable is 1, every clamp is 0, and `modeAck` and `dataInvalid` are 0.
- R2: In standby (`curMode` = 01) every chip enable is 0, every clamp is 0, and both supplies stay on.
- R3: In retention (`curMode` = 10) the chip enables are 0, the clamps are 1, periphery power is 0 and array power is 1. On entry the chip enable falls strictly before the clamp rises, and the clamp rises strictly before periphery power falls.
- R4: In shutdown (`curMode` = 11) the chip enables and both supplies are 0 and the clamps are 1. Array power never falls before periphery power has fallen.
- R5: On the way up, the clamp is released only after both supplies are on and only after more than `settleCount` cycles have passed since the last supply was restored. The chip enable rises only after the clamp has fallen.
- R6: `modeAck` is a single-cycle pulse, given only once `curMode` equals the requested level. A request for the current level is acknowledged with no change to any control.
- R7: The bank moves one level per step in the fixed order 00, 01, 10, 11 and back. A move between two distant levels shows every intermediate code on `curMode`.
- R8: While `inFlight` is 1, a request to leave the active level keeps the chip enables at 1 and withholds `modeAck`.
- R9: `accGrant` is 1 only when `accReq` is 1 and the bank is in the stable active level with no transition under way. Otherwise `accReq` gives `accStall` = 1.
- R10: `dataInvalid` is set by `accReq` while `curMode` = 11 and is cleared when the next mode request is accepted. An access request in standby or retention leaves it at 0.
- R11: Every macro of the bank receives identical chip enable, clamp, periphery and array controls at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeReq | input | 1 | Mode change request, held until `modeAck` |
| modeSel | input | 2 | Target level: 00 active, 01 standby, 10 retention, 11 shutdown |
| modeAck | output | 1 | One-cycle pulse when the target level is reached |
| curMode | output | 2 | Present level, same encoding as `modeSel` |
| settleCount | input | SETTLE_W | Cycles to wait after a supply is restored |
| inFlight | input | 1 | High while granted accesses are still outstanding |
| accReq | input | 1 | Access request from the bank user |
| accGrant | output | 1 | Access may proceed this cycle |
| accStall | output | 1 | Access request is held off |
| dataInvalid | output | 1 | Sticky flag: access attempted while shut down |
| memCen | output | NUM_MACROS | Per-macro chip enable, active high |
| clampEn | output | NUM_MACROS | Per-macro output clamp to zero, active high |
| periPwrEn | output | NUM_MACROS | Per-macro periphery supply enable |
| arrayPwrEn | output | NUM_MACROS | Per-macro array supply enable |

## Verification
The embedded properties assume that the requester keeps `modeReq` and `modeSel` steady from the moment it raises the request until it sees `modeAck`, and that it drops `modeReq` in the same cycle that the acknowledge appears. The acknowledge check compares `curMode` with the live `modeSel`, so it relies on that discipline. The stimulus drives all inputs on the falling edge. It lowers `modeReq` on the first falling edge at which `modeAck` is seen, and it never changes `modeSel` while a request is open. Access requests during a transition are kept apart from the cycle in which a request is accepted, so that the set and clear of the invalid flag never coincide.

// File: rtl/mem_lp_pkg.sv
package mem_lp_pkg;

  // Level codes double as the reported mode; numeric order is the step order.
  typedef enum logic [1:0] {
    LVL_ACTIVE  = 2'b00,
    LVL_STANDBY = 2'b01,
    LVL_RETAIN  = 2'b10,
    LVL_OFF     = 2'b11
  } lvl_e;

  // One-cycle strobes from the sequencer to the control datapath.
  typedef struct packed {
    logic setCen;
    logic clrCen;
    logic setClamp;
    logic clrClamp;
    logic setPeri;
    logic clrPeri;
    logic setArray;
    logic clrArray;
    logic loadSettle;
    logic inShutdown;
    logic clrFlag;
  } strobe_t;

endpackage

// File: rtl/mem_lp_fsm.sv
module mem_lp_fsm
  import mem_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeReq,
  input  logic [1:0] modeSel,
  input  logic       inFlight,
  input  logic       accReq,
  input  logic       settleDone,
  output strobe_t    stb,
  output logic [1:0] curMode,
  output logic       modeAck,
  output logic       accGrant,
  output logic       accStall
);

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_STEP,
    ST_DRAIN,
    ST_CLAMP,
    ST_PERI_OFF,
    ST_ARRAY_OFF,
    ST_ARRAY_ON,
    ST_WAIT_A,
    ST_PERI_ON,
    ST_WAIT_P,
    ST_UNCLAMP,
    ST_CEN_ON,
    ST_ACK
  } state_e;

  state_e state, nextState;
  lvl_e   level, nextLevel;
  lvl_e   tgt, nextTgt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_STABLE;
      level <= LVL_ACTIVE;
      tgt   <= LVL_ACTIVE;
    end else begin
      state <= nextState;
      level <= nextLevel;
      tgt   <= nextTgt;
    end
  end

  always_comb begin
    stb            = '0;
    stb.inShutdown = (level == LVL_OFF);
    nextState      = state;
    nextLevel      = level;
    nextTgt        = tgt;
    unique case (state)
      ST_STABLE: begin
        if (modeReq) begin
          nextTgt     = lvl_e'(modeSel);
          stb.clrFlag = 1'b1;
          nextState   = ST_STEP;
        end
      end
      ST_STEP: begin
        if (tgt == level) begin
          nextState = ST_ACK;
        end else if (tgt > level) begin
          unique case (level)
            LVL_ACTIVE:  nextState = ST_DRAIN;
            LVL_STANDBY: nextState = ST_CLAMP;
            default:     nextState = ST_ARRAY_OFF;
          endcase
        end else begin
          unique case (level)
            LVL_OFF:    nextState = ST_ARRAY_ON;
            LVL_RETAIN: nextState = ST_PERI_ON;
            default:    nextState = ST_CEN_ON;
          endcase
        end
      end
      ST_DRAIN: begin
        if (!inFlight) begin
          stb.clrCen = 1'b1;
          nextLevel  = LVL_STANDBY;
          nextState  = ST_STEP;
        end
      end
      ST_CLAMP: begin
        stb.setClamp = 1'b1;
        nextState    = ST_PERI_OFF;
      end
      ST_PERI_OFF: begin
        stb.clrPeri = 1'b1;
        nextLevel   = LVL_RETAIN;
        nextState   = ST_STEP;
      end
      ST_ARRAY_OFF: begin
        stb.clrArray = 1'b1;
        nextLevel    = LVL_OFF;
        nextState    = ST_STEP;
      end
      ST_ARRAY_ON: begin
        stb.setArray   = 1'b1;
        stb.loadSettle = 1'b1;
        nextState      = ST_WAIT_A;
      end
      ST_WAIT_A: begin
        if (settleDone) begin
          nextLevel = LVL_RETAIN;
          nextState = ST_STEP;
        end
      end
      ST_PERI_ON: begin
        stb.setPeri    = 1'b1;
        stb.loadSettle = 1'b1;
        nextState      = ST_WAIT_P;
      end
      ST_WAIT_P: begin
        if (settleDone) nextState = ST_UNCLAMP;
      end
      ST_UNCLAMP: begin
        stb.clrClamp = 1'b1;
        nextLevel    = LVL_STANDBY;
        nextState    = ST_STEP;
      end
      ST_CEN_ON: begin
        stb.setCen = 1'b1;
        nextLevel  = LVL_ACTIVE;
        nextState  = ST_STEP;
      end
      ST_ACK: begin
        nextState = ST_STABLE;
      end
      default: nextState = ST_STABLE;
    endcase
  end

  assign curMode  = level;
  assign modeAck  = (state == ST_ACK);
  assign accGrant = accReq && (state == ST_STABLE) && (level == LVL_ACTIVE);
  assign accStall = accReq && !accGrant;

  AST_ACK_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rstN)
    modeAck |-> (curMode == modeSel)) else $error("ack at wrong level"); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    modeAck |=> !modeAck) else $error("ack longer than one cycle"); // R6

endmodule

// File: rtl/mem_lp_dp.sv
module mem_lp_dp
  import mem_lp_pkg::*;
#(
  parameter int NUM_MACROS = 37,
  parameter int SETTLE_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [SETTLE_W-1:0]   settleCount,
  input  logic                  accReq,
  output logic                  settleDone,
  output logic                  dataInvalid,
  output logic [NUM_MACROS-1:0] memCen,
  output logic [NUM_MACROS-1:0] clampEn,
  output logic [NUM_MACROS-1:0] periPwrEn,
  output logic [NUM_MACROS-1:0] arrayPwrEn
);

  logic                cenReg, clampReg, periReg, arrayReg;
  logic [SETTLE_W-1:0] settleCnt;
  logic                invalidReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cenReg   <= 1'b1;
      clampReg <= 1'b0;
      periReg  <= 1'b1;
      arrayReg <= 1'b1;
    end else begin
      if (stb.setCen)        cenReg   <= 1'b1;
      else if (stb.clrCen)   cenReg   <= 1'b0;
      if (stb.setClamp)      clampReg <= 1'b1;
      else if (stb.clrClamp) clampReg <= 1'b0;
      if (stb.setPeri)       periReg  <= 1'b1;
      else if (stb.clrPeri)  periReg  <= 1'b0;
      if (stb.setArray)      arrayReg <= 1'b1;
      else if (stb.clrArray) arrayReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (stb.loadSettle)   settleCnt <= settleCount;
    else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  assign settleDone = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) invalidReg <= 1'b0;
    else       invalidReg <= (invalidReg & ~stb.clrFlag) | (accReq & stb.inShutdown);
  end

  assign dataInvalid = invalidReg;

  // Per-macro fan-out of the shared control state.
  for (genvar m = 0; m < NUM_MACROS; m++) begin : gMacro
    assign memCen[m]     = cenReg;
    assign clampEn[m]    = clampReg;
    assign periPwrEn[m]  = periReg;
    assign arrayPwrEn[m] = arrayReg;
  end

  AST_CLAMP_BEFORE_PERI_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(periReg) |-> $past(clampReg)) else $error("periphery cut unclamped"); // R3
  AST_CEN_LOW_WHEN_CLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    clampReg |-> !cenReg) else $error("selected while clamped"); // R3
  AST_ARRAY_OFF_AFTER_PERI: assert property (@(posedge clk) disable iff (!rstN)
    !arrayReg |-> !periReg) else $error("array off with periphery on"); // R4
  AST_UNCLAMP_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clampReg) |-> (periReg && arrayReg)) else $error("unclamp unpowered"); // R5
  AST_CEN_RISE_UNCLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cenReg) |-> !clampReg) else $error("select before unclamp"); // R5

endmodule

// File: rtl/mem_lp_ctrl.sv
module mem_lp_ctrl
  import mem_lp_pkg::*;
#(
  parameter int NUM_MACROS = 37,
  parameter int SETTLE_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeReq,
  input  logic [1:0]            modeSel,
  output logic                  modeAck,
  output logic [1:0]            curMode,
  input  logic [SETTLE_W-1:0]   settleCount,
  input  logic                  inFlight,
  input  logic                  accReq,
  output logic                  accGrant,
  output logic                  accStall,
  output logic                  dataInvalid,
  output logic [NUM_MACROS-1:0] memCen,
  output logic [NUM_MACROS-1:0] clampEn,
  output logic [NUM_MACROS-1:0] periPwrEn,
  output logic [NUM_MACROS-1:0] arrayPwrEn
);

  strobe_t stb;
  logic    settleDone;

  mem_lp_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .modeReq    (modeReq),
    .modeSel    (modeSel),
    .inFlight   (inFlight),
    .accReq     (accReq),
    .settleDone (settleDone),
    .stb        (stb),
    .curMode    (curMode),
    .modeAck    (modeAck),
    .accGrant   (accGrant),
    .accStall   (accStall)
  );

  mem_lp_dp #(
    .NUM_MACROS (NUM_MACROS),
    .SETTLE_W   (SETTLE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .settleCount (settleCount),
    .accReq      (accReq),
    .settleDone  (settleDone),
    .dataInvalid (dataInvalid),
    .memCen      (memCen),
    .clampEn     (clampEn),
    .periPwrEn   (periPwrEn),
    .arrayPwrEn  (arrayPwrEn)
  );

  AST_GRANT_NEEDS_CEN: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (&memCen && !(|clampEn))) else $error("grant while deselected"); // R9

endmodule

// File: tb/mem_lp_ctrl_tb.sv
`timescale 1ns/1ps
module mem_lp_ctrl_tb;

  localparam int N  = 37;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeReq = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic          modeAck;
  logic [1:0]    curMode;
  logic [SW-1:0] settleCount = '0;
  logic          inFlight = 1'b0;
  logic          accReq = 1'b0;
  logic          accGrant, accStall, dataInvalid;
  logic [N-1:0]  memCen, clampEn, periPwrEn, arrayPwrEn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  mem_lp_ctrl #(.NUM_MACROS(N), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .modeSel(modeSel),
    .modeAck(modeAck), .curMode(curMode), .settleCount(settleCount),
    .inFlight(inFlight), .accReq(accReq), .accGrant(accGrant),
    .accStall(accStall), .dataInvalid(dataInvalid), .memCen(memCen),
    .clampEn(clampEn), .periPwrEn(periPwrEn), .arrayPwrEn(arrayPwrEn)
  );

  // Edge stamps and level history, sampled on the falling edge.
  int tCenFall, tCenRise, tClampRise, tClampFall;
  int tPeriFall, tPeriRise, tArrayFall, tArrayRise;
  logic [15:0] seqWord;
  int seqLen;
  logic pCen = 1'b1, pClamp = 1'b0, pPeri = 1'b1, pArr = 1'b1;
  logic [1:0] lastMode = 2'b00;

  always @(negedge clk) begin
    if (curMode !== lastMode) begin
      seqWord = {seqWord[13:0], curMode};
      seqLen++;
    end
    if (pCen && !memCen[0])        tCenFall   = cyc;
    if (!pCen && memCen[0])        tCenRise   = cyc;
    if (!pClamp && clampEn[0])     tClampRise = cyc;
    if (pClamp && !clampEn[0])     tClampFall = cyc;
    if (pPeri && !periPwrEn[0])    tPeriFall  = cyc;
    if (!pPeri && periPwrEn[0])    tPeriRise  = cyc;
    if (pArr && !arrayPwrEn[0])    tArrayFall = cyc;
    if (!pArr && arrayPwrEn[0])    tArrayRise = cyc;
    lastMode = curMode;
    pCen = memCen[0]; pClamp = clampEn[0]; pPeri = periPwrEn[0]; pArr = arrayPwrEn[0];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req, input logic cen, input logic clamp,
                            input logic peri, input logic arr, input logic [1:0] mode);
    chk({req, " cen"},   memCen,     {N{cen}});
    chk({req, " clamp"}, clampEn,    {N{clamp}});
    chk({req, " peri"},  periPwrEn,  {N{peri}});
    chk({req, " array"}, arrayPwrEn, {N{arr}});
    chk({req, " mode"},  curMode,    mode);
    // R11: all macros share one set of controls
    chk("R11 uniform", {(memCen == '0 || memCen == '1), (clampEn == '0 || clampEn == '1),
                        (periPwrEn == '0 || periPwrEn == '1),
                        (arrayPwrEn == '0 || arrayPwrEn == '1)}, 4'hF);
  endtask

  task automatic startReq(input logic [1:0] tgt);
    @(negedge clk);
    tCenFall = -1; tCenRise = -1; tClampRise = -1; tClampFall = -1;
    tPeriFall = -1; tPeriRise = -1; tArrayFall = -1; tArrayRise = -1;
    seqWord = {14'b0, curMode};
    seqLen = 1;
    modeSel = tgt;
    modeReq = 1'b1;
  endtask

  task automatic waitAck();
    int n = 0;
    while (n < 500) begin
      @(negedge clk);
      if (modeAck) break;
      n++;
    end
    chk("R6 ack seen", modeAck, 1'b1);
    chk("R6 ack at target", curMode, modeSel);
    modeReq = 1'b0;
    @(negedge clk);
    chk("R6 ack one cycle", modeAck, 1'b0);
  endtask

  task automatic tReset();
    checkState("R1 reset", 1, 0, 1, 1, 2'b00);
    chk("R1 ack idle", modeAck, 1'b0);
    chk("R1 flag idle", dataInvalid, 1'b0);
  endtask

  task automatic tDrainStandby();
    inFlight = 1'b1;
    startReq(2'b01);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 cen held while draining", memCen, {N{1'b1}});
      chk("R8 no ack while draining", modeAck, 1'b0);
    end
    inFlight = 1'b0;
    waitAck();
    checkState("R2 standby", 0, 0, 1, 1, 2'b01);
  endtask

  task automatic tSameLevel();
    startReq(2'b01);
    waitAck();
    chk("R6 same level no steps", seqLen, 1);
    checkState("R6 same level unchanged", 0, 0, 1, 1, 2'b01);
  endtask

  task automatic tWakeStandby();
    settleCount = 8'd3;
    startReq(2'b00);
    waitAck();
    chk("R7 standby to active", {seqLen[3:0], seqWord[3:0]}, {4'd2, 4'b0100});
    checkState("R5 active again", 1, 0, 1, 1, 2'b00);
  endtask

  task automatic tGrantActive();
    @(negedge clk);
    accReq = 1'b1;
    #1;
    chk("R9 grant in active", {accGrant, accStall}, 2'b10);
    @(negedge clk);
    accReq = 1'b0;
  endtask

  task automatic tToRetention();
    startReq(2'b10);
    waitAck();
    chk("R7 active to retention", {seqLen[3:0], seqWord[5:0]}, {4'd3, 6'b000110});
    chk("R3 cen before clamp", (tCenFall >= 0) && (tCenFall < tClampRise), 1'b1);
    chk("R3 clamp before peri off", (tClampRise >= 0) && (tClampRise < tPeriFall), 1'b1);
    checkState("R3 retention", 0, 1, 0, 1, 2'b10);
    accReq = 1'b1;
    #1;
    chk("R9 stall in retention", {accGrant, accStall}, 2'b01);
    @(negedge clk);
    accReq = 1'b0;
    @(negedge clk);
    chk("R10 no flag in retention", dataInvalid, 1'b0);
  endtask

  task automatic tToShutdown();
    startReq(2'b11);
    waitAck();
    chk("R7 retention to shutdown", {seqLen[3:0], seqWord[3:0]}, {4'd2, 4'b1011});
    checkState("R4 shutdown", 0, 1, 0, 0, 2'b11);
    accReq = 1'b1;
    #1;
    chk("R9 stall in shutdown", {accGrant, accStall}, 2'b01);
    @(negedge clk);
    accReq = 1'b0;
    @(negedge clk);
    chk("R10 flag set in shutdown", dataInvalid, 1'b1);
  endtask

  task automatic tWakeShutdown();
    settleCount = 8'd5;
    startReq(2'b00);
    waitAck();
    chk("R7 shutdown to active", {seqLen[3:0], seqWord[7:0]}, {4'd4, 8'b11100100});
    chk("R5 settle after periphery", (tPeriRise >= 0) && (tClampFall - tPeriRise > 5), 1'b1);
    chk("R5 settle after array", (tArrayRise >= 0) && (tClampFall - tArrayRise > 5), 1'b1);
    chk("R5 cen after unclamp", (tClampFall >= 0) && (tCenRise > tClampFall), 1'b1);
    checkState("R5 woken", 1, 0, 1, 1, 2'b00);
    chk("R10 flag cleared", dataInvalid, 1'b0);
  endtask

  task automatic tDirectShutdown();
    startReq(2'b11);
    waitAck();
    chk("R7 active to shutdown", {seqLen[3:0], seqWord[7:0]}, {4'd4, 8'b00011011});
    chk("R3 clamp before peri off", (tClampRise >= 0) && (tClampRise < tPeriFall), 1'b1);
    chk("R4 array after peri", (tPeriFall >= 0) && (tArrayFall > tPeriFall), 1'b1);
    checkState("R4 shutdown direct", 0, 1, 0, 0, 2'b11);
  endtask

  task automatic tShutToRetention();
    settleCount = 8'd0;
    startReq(2'b10);
    waitAck();
    chk("R7 shutdown to retention", {seqLen[3:0], seqWord[3:0]}, {4'd2, 4'b1110});
    checkState("R3 retention from shutdown", 0, 1, 0, 1, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDrainStandby();
    tSameLevel();
    tWakeStandby();
    tGrantActive();
    tToRetention();
    tToShutdown();
    tWakeShutdown();
    tDirectShutdown();
    tShutToRetention();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule